// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block rebuilds the four integer condition flags of a 32-bit processor (negative, zero, overflow and carry) from what the execution stage recorded earlier: a class code for the operation, the result it produced and its second (source) operand. The datapath stores only that triple and asks for real flags when a branch or a flag read needs them. A one-cycle evaluate request then yields a registered flag vector with a valid strobe.

The first operand is never stored, so for each class it is recovered from the result and the source. Add-with-extend and subtract-with-extend keep a sticky zero flag across a multi-word chain: the caller supplies the zero flag from the previous evaluation and the new zero can only stay set or be cleared. Narrow compares apply the subtract rule at byte and halfword width. An unknown class code is reported on an error output.

Top module: `deferred_cc_unit`

## Requirements
- R1: Flag vector layout is {N,Z,V,C} with C in bit 0 and N in bit 3. Class code 0 (direct) copies bits 3:0 of the result word into the flag vector unchanged.
- R2: For every computed class (codes 1 to 8) Z is set exactly when the evaluated result is zero, and N is set exactly when that result is nonzero with its top bit one, so N and Z never appear together.
- R3: Class code 1 (logic) gives N and Z from the 32-bit result with V and C both zero.
- R4: Class code 2 (add): with the first operand taken as result minus source, C is the carry out of first operand plus source (result unsigned-below source) and V is set when first operand and source share a sign that the result does not.
- R5: Class code 6 (add with extend): the first operand is result minus source minus one and C is the carry out of first operand plus source plus one (result unsigned-at-or-below source); V follows the rule of R4 with that first operand.
- R6: Class code 3 (subtract): the minuend is result plus source; C is the borrow of minuend minus source and V is set when minuend and source differ in sign and the result's sign differs from the minuend's.
- R7: Class code 7 (subtract with extend): the minuend is result plus source plus one, C is the borrow of minuend minus source minus one, V as in R6.
- R8: Class codes 4 and 5 apply the rule of R6 to the low 8 and low 16 bits of result and source, with N, Z, V and C all taken at that width; the upper bits have no effect.
- R9: Class code 8 (shift): N and Z from the result, V zero, C set when the source word is nonzero.
- R10: For classes 6 and 7 the output Z is the computed Z ANDed with the prior_z input; for all other classes prior_z has no effect.
- R11: After reset flags_out, flags_vld and op_err are zero. A request sampled on a rising edge presents flags and a one-cycle flags_vld after that edge; without a request flags_out holds its value.
- R12: Class codes 9 to 15 are illegal: the response carries op_err high together with flags_vld, and flags_out becomes 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_req | input | 1 | Evaluate the presented triple this cycle |
| op_code | input | 4 | Recorded operation class |
| res_val | input | 32 | Recorded result word |
| src_val | input | 32 | Recorded source operand |
| prior_z | input | 1 | Zero flag from the previous evaluation (extend classes) |
| flags_out | output | 4 | Registered flags {N,Z,V,C} |
| flags_vld | output | 1 | One-cycle strobe, flags_out updated |
| op_err | output | 1 | Response was for an illegal class code |

## Verification
The overlap that matters is a new evaluate request being captured in the same cycle that the previous response is presented, including a legal response followed directly by an illegal code and an extend-class request whose sticky zero depends on prior_z. Back-to-back requests of mixed classes are issued on consecutive cycles, each expected response is queued at issue time, and a monitor pops and compares every strobe against the independently computed flags while also checking that flags_out holds in idle cycles.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

   localparam int OPC_W  = 4;
   localparam int FLAG_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_DIRECT = 4'd0,
      OPC_LOGIC  = 4'd1,
      OPC_ADD    = 4'd2,
      OPC_SUB    = 4'd3,
      OPC_CMP8   = 4'd4,
      OPC_CMP16  = 4'd5,
      OPC_ADDX   = 4'd6,
      OPC_SUBX   = 4'd7,
      OPC_SHIFT  = 4'd8
   } opc_e;

   // bit 3 .. bit 0 : N Z V C
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/cc_nz.sv
module cc_nz #(
   parameter int W = 32
) (
   input  logic [W-1:0] val,
   output logic         n,
   output logic         z
);
   always_comb begin
      z = (val == '0);
      n = !z && val[W-1];
   end
endmodule

// File: rtl/cc_add_rule.sv
module cc_add_rule #(
   parameter int W = 32
) (
   input  logic [W-1:0] res,
   input  logic [W-1:0] src,
   input  logic         cin,
   output logic         n,
   output logic         z,
   output logic         v,
   output logic         c
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] first_op;

   cc_nz #(.W(W)) u_nz (.val(res), .n(n), .z(z));

   always_comb begin
      first_op = cin ? (res - src - ONE) : (res - src);
      c = cin ? (res <= src) : (res < src);
      v = (first_op[W-1] == src[W-1]) && (res[W-1] != src[W-1]);
   end
endmodule

// File: rtl/cc_sub_rule.sv
module cc_sub_rule #(
   parameter int W = 32
) (
   input  logic [W-1:0] res,
   input  logic [W-1:0] src,
   input  logic         bin,
   output logic         n,
   output logic         z,
   output logic         v,
   output logic         c
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] minuend;
   logic [W-1:0] diff_m;

   cc_nz #(.W(W)) u_nz (.val(res), .n(n), .z(z));

   always_comb begin
      minuend = bin ? (res + src + ONE) : (res + src);
      c       = bin ? (minuend <= src) : (minuend < src);
      diff_m  = (minuend ^ res) & (minuend ^ src);
      v       = diff_m[W-1];
   end
endmodule

// File: rtl/cc_flag_core.sv
module cc_flag_core
   import ccx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int MID_W    = 16,
   parameter int NARROW_W = 8
) (
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] res,
   input  logic [DATA_W-1:0] src,
   input  logic              pz,
   output flags_t            flags,
   output logic              err
);
   localparam int LANES = 3;

   function automatic int lane_w(input int idx);
      return (idx == 0) ? DATA_W : ((idx == 1) ? MID_W : NARROW_W);
   endfunction

   logic             is_addx, is_subx;
   logic             full_n, full_z;
   logic             add_n, add_z, add_v, add_c;
   logic [LANES-1:0] ln_n, ln_z, ln_v, ln_c;

   assign is_addx = (op == OPC_ADDX);
   assign is_subx = (op == OPC_SUBX);

   cc_nz #(.W(DATA_W)) u_full_nz (.val(res), .n(full_n), .z(full_z));

   cc_add_rule #(.W(DATA_W)) u_add (
      .res(res), .src(src), .cin(is_addx),
      .n(add_n), .z(add_z), .v(add_v), .c(add_c)
   );

   // lane 0: full-width subtract (and extend), lane 1: halfword, lane 2: byte
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LW = lane_w(g);
      cc_sub_rule #(.W(LW)) u_sub (
         .res(res[LW-1:0]), .src(src[LW-1:0]),
         .bin((g == 0) ? is_subx : 1'b0),
         .n(ln_n[g]), .z(ln_z[g]), .v(ln_v[g]), .c(ln_c[g])
      );
   end

   always_comb begin
      flags = '0;
      err   = 1'b0;
      case (op)
         OPC_DIRECT: flags = flags_t'(res[FLAG_W-1:0]);
         OPC_LOGIC: begin
            flags.n = full_n;
            flags.z = full_z;
         end
         OPC_ADD, OPC_ADDX: begin
            flags.n = add_n;
            flags.z = add_z && (!is_addx || pz);
            flags.v = add_v;
            flags.c = add_c;
         end
         OPC_SUB, OPC_SUBX: begin
            flags.n = ln_n[0];
            flags.z = ln_z[0] && (!is_subx || pz);
            flags.v = ln_v[0];
            flags.c = ln_c[0];
         end
         OPC_CMP16: flags = '{n: ln_n[1], z: ln_z[1], v: ln_v[1], c: ln_c[1]};
         OPC_CMP8:  flags = '{n: ln_n[2], z: ln_z[2], v: ln_v[2], c: ln_c[2]};
         OPC_SHIFT: begin
            flags.n = full_n;
            flags.z = full_z;
            flags.c = (src != '0);
         end
         default: err = 1'b1;
      endcase
   end
endmodule

// File: rtl/deferred_cc_unit.sv
module deferred_cc_unit
   import ccx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int MID_W    = 16,
   parameter int NARROW_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eval_req,
   input  logic [OPC_W-1:0]    op_code,
   input  logic [DATA_W-1:0]   res_val,
   input  logic [DATA_W-1:0]   src_val,
   input  logic                prior_z,
   output logic [FLAG_W-1:0]   flags_out,
   output logic                flags_vld,
   output logic                op_err
);
   if (NARROW_W < 2 || NARROW_W >= MID_W || MID_W >= DATA_W) begin : g_bad_widths
      $error("deferred_cc_unit: need 2 <= NARROW_W < MID_W < DATA_W");
   end
   if (DATA_W < FLAG_W) begin : g_bad_data
      $error("deferred_cc_unit: DATA_W must hold the direct flag field");
   end

   flags_t             nxt_flags;
   logic               nxt_err;
   logic [OPC_W-1:0]   opc_q;
   logic               pz_q;

   cc_flag_core #(.DATA_W(DATA_W), .MID_W(MID_W), .NARROW_W(NARROW_W)) u_core (
      .op(op_code), .res(res_val), .src(src_val), .pz(prior_z),
      .flags(nxt_flags), .err(nxt_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_out <= '0;
         flags_vld <= 1'b0;
         op_err    <= 1'b0;
         opc_q     <= '0;
         pz_q      <= 1'b0;
      end else begin
         flags_vld <= eval_req;
         op_err    <= eval_req && nxt_err;
         if (eval_req) begin
            flags_out <= nxt_err ? '0 : nxt_flags;
            opc_q     <= op_code;
            pz_q      <= prior_z;
         end
      end
   end

   // R11: strobe follows the request by exactly one edge
   assert_vld_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      eval_req |=> flags_vld);
   assert_vld_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_req |=> !flags_vld);
   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_req |=> $stable(flags_out));
   // R2: computed classes never report N and Z together
   assert_nz_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_vld && opc_q != OPC_DIRECT) |-> !(flags_out[3] && flags_out[2]));
   // R3: logic class clears V and C
   assert_logic_vc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_vld && opc_q == OPC_LOGIC) |-> (flags_out[1:0] == 2'b00));
   // R10: sticky zero can only be cleared
   assert_sticky_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_vld && (opc_q == OPC_ADDX || opc_q == OPC_SUBX) && !pz_q) |-> !flags_out[2]);
   // R9: shift never reports overflow
   assert_shift_nov_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_vld && opc_q == OPC_SHIFT) |-> !flags_out[1]);
   // R12: error comes only with the strobe and zero flags
   assert_err_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
      op_err |-> (flags_vld && flags_out == '0));
endmodule

// File: tb/tb_deferred_cc_unit.sv
module tb_deferred_cc_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eval_req = 1'b0;
   logic [3:0]  op_code = '0;
   logic [31:0] res_val = '0;
   logic [31:0] src_val = '0;
   logic        prior_z = 1'b0;
   logic [3:0]  flags_out;
   logic        flags_vld;
   logic        op_err;

   deferred_cc_unit dut (
      .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .op_code(op_code),
      .res_val(res_val), .src_val(src_val), .prior_z(prior_z),
      .flags_out(flags_out), .flags_vld(flags_vld), .op_err(op_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [4:0] exp;
      string      tag;
   } item_t;

   item_t       sb[$];
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          mon_on   = 1'b0;
   bit          done     = 1'b0;
   logic [3:0]  last_flags = '0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected {err,N,Z,V,C} from the requirements
   function automatic logic [4:0] model(input logic [3:0] op, input logic [31:0] r,
                                        input logic [31:0] s, input logic pz);
      logic n, z, v, c;
      logic [31:0] a;
      logic [32:0] w;
      logic [16:0] w16;
      logic [8:0]  w8;
      logic [15:0] m16;
      logic [7:0]  m8;
      z = (r == 0);
      n = !z && r[31];
      v = 1'b0;
      c = 1'b0;
      case (op)
         4'd0: return {1'b0, r[3:0]};
         4'd1: ;
         4'd2: begin
            a = r - s;
            w = {1'b0, a} + {1'b0, s};
            c = w[32];
            v = (a[31] == s[31]) && (r[31] != a[31]);
         end
         4'd6: begin
            a = r - s - 32'd1;
            w = {1'b0, a} + {1'b0, s} + 33'd1;
            c = w[32];
            v = (a[31] == s[31]) && (r[31] != a[31]);
            z = z && pz;
         end
         4'd3, 4'd7: begin
            a = r + s + ((op == 4'd7) ? 32'd1 : 32'd0);
            w = {1'b0, a} - {1'b0, s} - ((op == 4'd7) ? 33'd1 : 33'd0);
            c = w[32];
            v = (a[31] != s[31]) && (r[31] != a[31]);
            if (op == 4'd7) z = z && pz;
         end
         4'd5: begin
            m16 = r[15:0] + s[15:0];
            w16 = {1'b0, m16} - {1'b0, s[15:0]};
            c = w16[16];
            v = (m16[15] != s[15]) && (r[15] != m16[15]);
            z = (r[15:0] == 0);
            n = !z && r[15];
         end
         4'd4: begin
            m8 = r[7:0] + s[7:0];
            w8 = {1'b0, m8} - {1'b0, s[7:0]};
            c = w8[8];
            v = (m8[7] != s[7]) && (r[7] != m8[7]);
            z = (r[7:0] == 0);
            n = !z && r[7];
         end
         4'd8: c = (s != 0);
         default: return 5'b10000;
      endcase
      return {1'b0, n, z, v, c};
   endfunction

   function automatic string op_tag(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3: return "R6";
         4'd4, 4'd5: return "R8";
         4'd6: return "R5";
         4'd7: return "R7";
         4'd8: return "R9";
         default: return "R12";
      endcase
   endfunction

   // driver: present one request at a falling edge and queue its expectation
   task automatic send(input logic [3:0] op, input logic [31:0] r, input logic [31:0] s,
                       input logic pz, input string tag);
      item_t it;
      @(negedge clk);
      op_code  = op;
      res_val  = r;
      src_val  = s;
      prior_z  = pz;
      eval_req = 1'b1;
      it.exp = model(op, r, s, pz);
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         eval_req = 1'b0;
         op_code  = 4'($urandom_range(0, 15));
         res_val  = $urandom;
         src_val  = $urandom;
         prior_z  = 1'($urandom_range(0, 1));
      end
   endtask

   // monitor: compare every strobe, check holding in idle cycles
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (flags_vld) begin
            if (sb.size() == 0) begin
               check(1'b0, "R11 unexpected strobe", 32'(flags_out), 32'h0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check({op_err, flags_out} == it.exp, it.tag,
                     32'({op_err, flags_out}), 32'(it.exp));
               last_flags = flags_out;
            end
         end else begin
            check(flags_out == last_flags && !op_err, "R11 hold",
                  32'({op_err, flags_out}), 32'(last_flags));
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(flags_out == 4'h0 && !flags_vld && !op_err, "R11 reset state",
            32'({flags_vld, op_err, flags_out}), 32'h0);
      mon_on = 1'b1;

      // R1 direct pass-through, upper bits ignored
      send(4'd0, 32'hFFFF_FFF5, 32'h0, 1'b0, "R1 direct 0101");
      send(4'd0, 32'h0000_000A, 32'h1234, 1'b1, "R1 direct 1010");
      // R3 logic: zero, negative, positive
      send(4'd1, 32'h0, 32'hFFFF_FFFF, 1'b0, "R3 R2 logic zero");
      send(4'd1, 32'h8000_0001, 32'h1, 1'b0, "R3 R2 logic negative");
      send(4'd1, 32'h0000_7000, 32'h0, 1'b0, "R3 logic positive");
      idle(2);
      // R4 add: signed overflow, carry to zero
      send(4'd2, 32'h8000_0000, 32'h1, 1'b0, "R4 add overflow");
      send(4'd2, 32'h0, 32'h1, 1'b0, "R4 add carry zero");
      send(4'd2, 32'h5, 32'h3, 1'b0, "R4 add plain");
      // R5 add extend: equality edge of carry, sticky zero
      send(4'd6, 32'h3, 32'h3, 1'b1, "R5 addx carry at equal");
      send(4'd6, 32'h0, 32'hFFFF_FFFF, 1'b1, "R5 R10 addx zero kept");
      send(4'd6, 32'h0, 32'hFFFF_FFFF, 1'b0, "R10 addx zero cleared");
      // R6 subtract
      send(4'd3, 32'h7FFF_FFFF, 32'h1, 1'b0, "R6 sub overflow");
      send(4'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, "R6 sub borrow");
      send(4'd3, 32'h0, 32'h9, 1'b0, "R6 R10 sub zero ignores prior_z");
      // R7 subtract extend
      send(4'd7, 32'hFFFF_FFFF, 32'h0, 1'b1, "R7 subx borrow at equal");
      send(4'd7, 32'h0, 32'h5, 1'b0, "R7 R10 subx zero cleared");
      send(4'd7, 32'h0, 32'h5, 1'b1, "R7 R10 subx zero kept");
      idle(1);
      // R8 narrow compares
      send(4'd4, 32'h1234_5680, 32'hABCD_EF01, 1'b0, "R8 cmp byte");
      send(4'd4, 32'hFFFF_FF00, 32'h0000_0010, 1'b0, "R8 cmp byte zero");
      send(4'd5, 32'h0000_8000, 32'hFFFF_0001, 1'b0, "R8 cmp half");
      send(4'd5, 32'h8765_7FFF, 32'h0000_0001, 1'b0, "R8 cmp half overflow");
      // R9 shift
      send(4'd8, 32'h8000_0000, 32'h1, 1'b0, "R9 shift carry");
      send(4'd8, 32'h0, 32'h0, 1'b0, "R9 shift no carry");
      // R12 illegal codes right after legal ones
      send(4'd9, 32'h1, 32'h1, 1'b0, "R12 code 9");
      send(4'd2, 32'h0, 32'h1, 1'b0, "R4 after error");
      send(4'd15, 32'h0, 32'h0, 1'b1, "R12 code 15");
      idle(3);

      // mixed stream with gaps and back-to-back requests
      for (int k = 0; k < 400; k++) begin
         logic [3:0]  op;
         logic [31:0] r, s;
         op = (($urandom_range(0, 9)) == 0) ? 4'($urandom_range(9, 15))
                                            : 4'($urandom_range(0, 8));
         r = $urandom;
         s = $urandom;
         case ($urandom_range(0, 5))
            0: r = 32'h0;
            1: s = r;
            2: r = {24'h0, r[7:0]};
            default: ;
         endcase
         send(op, r, s, 1'($urandom_range(0, 1)), op_tag(op));
         if ($urandom_range(0, 3) == 0) idle(1);
      end
      idle(4);
      check(sb.size() == 0, "R11 all responses seen", 32'(sb.size()), 32'h0);
      finish_run();
   end
endmodule